// File: doc/BRIEF.md
# Multi-Match Timer Bank with Selectable Reload

This block holds a bank of up-counting timers behind one synchronous register bus. Each timer has several match comparators, a preload value and a reload selector. The selector names the comparator whose match puts the preload value back into the counter; with no comparator named, the counter simply wraps. Every comparator raises a one-cycle match pulse and sets a sticky status bit, and both are available as output pins.

Counting normally follows a slow functional clock-enable strobe. A clock-select bit can instead make the enabled timers step on every clock. Software never reads a live counter. It writes a request to a timer's capture register, and after two functional strobes the capture register holds a stable copy of the count. Until then, reads return the previous copy.

The bus has no wait states. A write lands at the clock edge on which `bus_we` is high, and reads are combinational from `bus_addr`. Word addresses: clock select 0, run enable 1, status 2, preload 4+t, reload selector 8+t, capture 12+t, match 16+3t+c, where t is the timer and c is the comparator.

Top module: `mmt_top`

## Requirements
- R1: After reset every counter, capture register, run enable bit, status bit, match pulse and the clock-select bit are 0, the reload selectors are 0, and every match register reads all ones.
- R2: Bit t of the run enable register (address 1) enables timer t. A disabled timer holds its count. An enabled timer adds one per counting tick.
- R3: With clock-select (address 0, bit 0) at 0, a counting tick is a clock edge with `fclk_en` high. With it at 1, every clock edge is a counting tick and `fclk_en` has no effect on counting.
- R4: A reload selector value k in 1..NUM_MATCH makes comparator k-1 the reload source. On a tick where the count equals that comparator's match value, the counter loads the preload value instead of incrementing. The value 0 disables reload. Matches on other comparators never reload.
- R5: Without a reload, a counter at all ones wraps to 0. Selecting comparator 0 with match all ones and preload 0 gives the same full-range count.
- R6: A new preload value written while a timer runs does not change the count until the next reload event, which then uses the new value.
- R7: Comparator c of timer t drives `match_pulse` bit 3t+c high for the one cycle after a counting tick on which the count equalled its match value.
- R8: Status bit 3t+c sets together with its match pulse and stays set until software writes 1 to that bit at address 2. Reads of address 2 return the status bits.
- R9: Writing bit 0 = 1 to capture register t starts a capture. On the second `fclk_en` strobe after the request, the register takes the timer's count. Until then it reads its previous value.
- R10: Match register 16+3t+c reads back the value last written to it.
- R11: Timers are independent. Enabling, matching or capturing on one timer changes no other timer's count or status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fclk_en | input | 1 | Functional clock-enable strobe |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register word address |
| bus_wdata | input | DATA_W | Register write data |
| bus_rdata | output | DATA_W | Register read data for `bus_addr` |
| match_pulse | output | NUM_TIMERS*NUM_MATCH | One-cycle match pulses, bit 3t+c |
| match_status | output | NUM_TIMERS*NUM_MATCH | Sticky match status, bit 3t+c |

## Verification
The bench builds the block with CNT_W = 8 and keeps three timers, three comparators, a 32-bit bus and two capture stages. The narrow counter puts the all-ones-to-zero wrap and the full-range reload within a few hundred ticks, so both the free-running wrap and the reload from comparator 0 are checked directly. The default bank shape exercises the 3t+c indexing of match registers and status bits across timer boundaries.

// File: rtl/mmt_pkg.sv
// Package: shared register word addresses of the multi-match timer bank.
// Assumes NUM_TIMERS <= 4 and NUM_TIMERS*NUM_MATCH <= 16 so regions never overlap.
package mmt_pkg;
    localparam int ADR_CLKSEL  = 0;
    localparam int ADR_ENABLE  = 1;
    localparam int ADR_STATUS  = 2;
    localparam int ADR_PRELOAD = 4;
    localparam int ADR_RSEL    = 8;
    localparam int ADR_CAPTURE = 12;
    localparam int ADR_MATCH   = 16;
endpackage

// File: rtl/mmt_channel.sv
// Module: one timer channel. Counter, NUM_MATCH comparators, reload choice, match pulses.
// Assumes tick already folds in the run enable and the clock choice.
module mmt_channel #(
    parameter int CNT_W     = 32,
    parameter int NUM_MATCH = 3,
    parameter int SEL_W     = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tick,
    input  logic [NUM_MATCH*CNT_W-1:0] match_vals,
    input  logic [CNT_W-1:0]           preload,
    input  logic [SEL_W-1:0]           reload_sel,
    output logic [CNT_W-1:0]           count,
    output logic [NUM_MATCH-1:0]       hit,
    output logic [NUM_MATCH-1:0]       pulse
);
    logic reload;

    // Compare the count against every match value on a counting tick.
    always_comb begin
        reload = 1'b0;
        for (int c = 0; c < NUM_MATCH; c++) begin
            hit[c] = tick && (count == match_vals[c*CNT_W +: CNT_W]);
            if (hit[c] && (reload_sel == SEL_W'(c + 1))) reload = 1'b1;
        end
    end

    // Advance the counter, or reload it from the preload value.
    always_ff @(posedge clk) begin
        if (!rst_n)    count <= '0;
        else if (tick) count <= reload ? preload : count + 1'b1;
    end

    // Register the comparator hits into one-cycle match pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) pulse <= '0;
        else        pulse <= hit;
    end
endmodule

// File: rtl/mmt_capture.sv
// Module: count capture for one timer. A request arms it, and on the SYNC_STAGES-th
// functional strobe afterwards the live count is copied. Assumes req is a single-cycle write.
module mmt_capture #(
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             fclk_en,
    input  logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] captured
);
    localparam int STG_W = (SYNC_STAGES > 1) ? $clog2(SYNC_STAGES) : 1;

    logic             pending;
    logic [STG_W-1:0] stage;

    // Track a pending request through the strobe stages, then take the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending  <= 1'b0;
            stage    <= '0;
            captured <= '0;
        end else if (req) begin
            pending <= 1'b1;
            stage   <= '0;
        end else if (pending && fclk_en) begin
            if (stage == STG_W'(SYNC_STAGES - 1)) begin
                captured <= count;
                pending  <= 1'b0;
            end else begin
                stage <= stage + 1'b1;
            end
        end
    end
endmodule

// File: rtl/mmt_top.sv
// Module: bank of NUM_TIMERS multi-match timers behind a zero-wait register bus.
// Holds the registers, the sticky status and the read mux. Instances one channel and one
// capture unit per timer. Assumes DATA_W >= CNT_W and DATA_W >= NUM_TIMERS*NUM_MATCH.
module mmt_top #(
    parameter int NUM_TIMERS  = 3,
    parameter int NUM_MATCH   = 3,
    parameter int CNT_W       = 32,
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             fclk_en,
    input  logic                             bus_we,
    input  logic [ADDR_W-1:0]                bus_addr,
    input  logic [DATA_W-1:0]                bus_wdata,
    output logic [DATA_W-1:0]                bus_rdata,
    output logic [NUM_TIMERS*NUM_MATCH-1:0]  match_pulse,
    output logic [NUM_TIMERS*NUM_MATCH-1:0]  match_status
);
    import mmt_pkg::*;

    localparam int NUM_CMP = NUM_TIMERS * NUM_MATCH;
    localparam int SEL_W   = $clog2(NUM_MATCH + 1);

    logic                                clksel_q;
    logic [NUM_TIMERS-1:0]               en_q;
    logic [NUM_TIMERS-1:0][CNT_W-1:0]    preload_q;
    logic [NUM_TIMERS-1:0][SEL_W-1:0]    rsel_q;
    logic [NUM_CMP-1:0][CNT_W-1:0]       match_q;
    logic [NUM_TIMERS-1:0][CNT_W-1:0]    count_all;
    logic [NUM_TIMERS-1:0][CNT_W-1:0]    cap_all;
    logic [NUM_CMP-1:0]                  hit_all;
    logic [NUM_CMP-1:0]                  status_clr;
    logic [NUM_TIMERS-1:0]               tick;
    logic [NUM_TIMERS-1:0]               cap_req;

    // Write the configuration registers from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clksel_q  <= 1'b0;
            en_q      <= '0;
            preload_q <= '0;
            rsel_q    <= '0;
            match_q   <= '1;
        end else if (bus_we) begin
            if (bus_addr == ADDR_W'(ADR_CLKSEL)) clksel_q <= bus_wdata[0];
            if (bus_addr == ADDR_W'(ADR_ENABLE)) en_q <= bus_wdata[NUM_TIMERS-1:0];
            for (int t = 0; t < NUM_TIMERS; t++) begin
                if (bus_addr == ADDR_W'(ADR_PRELOAD + t)) preload_q[t] <= bus_wdata[CNT_W-1:0];
                if (bus_addr == ADDR_W'(ADR_RSEL + t))    rsel_q[t]    <= bus_wdata[SEL_W-1:0];
            end
            for (int i = 0; i < NUM_CMP; i++) begin
                if (bus_addr == ADDR_W'(ADR_MATCH + i)) match_q[i] <= bus_wdata[CNT_W-1:0];
            end
        end
    end

    // Decode the write-one-to-clear mask for the status bits.
    always_comb begin
        status_clr = '0;
        if (bus_we && bus_addr == ADDR_W'(ADR_STATUS)) status_clr = bus_wdata[NUM_CMP-1:0];
    end

    // Sticky status: a new hit wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) match_status <= '0;
        else        match_status <= (match_status & ~status_clr) | hit_all;
    end

    // Per-timer tick gating, capture request decode, channel and capture unit.
    for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_timer
        assign tick[t]    = en_q[t] && (clksel_q || fclk_en);
        assign cap_req[t] = bus_we && (bus_addr == ADDR_W'(ADR_CAPTURE + t)) && bus_wdata[0];

        mmt_channel #(.CNT_W(CNT_W), .NUM_MATCH(NUM_MATCH), .SEL_W(SEL_W)) i_channel (
            .clk        (clk),
            .rst_n      (rst_n),
            .tick       (tick[t]),
            .match_vals (match_q[t*NUM_MATCH +: NUM_MATCH]),
            .preload    (preload_q[t]),
            .reload_sel (rsel_q[t]),
            .count      (count_all[t]),
            .hit        (hit_all[t*NUM_MATCH +: NUM_MATCH]),
            .pulse      (match_pulse[t*NUM_MATCH +: NUM_MATCH])
        );

        mmt_capture #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) i_capture (
            .clk      (clk),
            .rst_n    (rst_n),
            .req      (cap_req[t]),
            .fclk_en  (fclk_en),
            .count    (count_all[t]),
            .captured (cap_all[t])
        );
    end

    // Read mux: choose the addressed register, zero for unused addresses.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(ADR_CLKSEL)) bus_rdata[0] = clksel_q;
        if (bus_addr == ADDR_W'(ADR_ENABLE)) bus_rdata[NUM_TIMERS-1:0] = en_q;
        if (bus_addr == ADDR_W'(ADR_STATUS)) bus_rdata[NUM_CMP-1:0] = match_status;
        for (int t = 0; t < NUM_TIMERS; t++) begin
            if (bus_addr == ADDR_W'(ADR_PRELOAD + t)) bus_rdata = DATA_W'(preload_q[t]);
            if (bus_addr == ADDR_W'(ADR_RSEL + t))    bus_rdata = DATA_W'(rsel_q[t]);
            if (bus_addr == ADDR_W'(ADR_CAPTURE + t)) bus_rdata = DATA_W'(cap_all[t]);
        end
        for (int i = 0; i < NUM_CMP; i++) begin
            if (bus_addr == ADDR_W'(ADR_MATCH + i)) bus_rdata = DATA_W'(match_q[i]);
        end
    end
endmodule

// File: rtl/mmt_checker.sv
// Module: assertion checker for mmt_top, attached with the bind below.
// Observes the ports and the run enable, clock-select, count and capture state.
module mmt_checker #(
    parameter int NUM_TIMERS = 3,
    parameter int NUM_MATCH  = 3,
    parameter int CNT_W      = 32,
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 5
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            fclk_en,
    input logic                            bus_we,
    input logic [ADDR_W-1:0]               bus_addr,
    input logic [DATA_W-1:0]               bus_wdata,
    input logic                            clksel_q,
    input logic [NUM_TIMERS-1:0]           en_q,
    input logic [NUM_TIMERS*CNT_W-1:0]     count_all,
    input logic [NUM_TIMERS*CNT_W-1:0]     cap_all,
    input logic [NUM_TIMERS*NUM_MATCH-1:0] match_pulse,
    input logic [NUM_TIMERS*NUM_MATCH-1:0] match_status
);
    import mmt_pkg::*;

    for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_t
        // R2: a disabled timer keeps its count.
        p_hold_when_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
            !en_q[t] |=> count_all[t*CNT_W +: CNT_W] == $past(count_all[t*CNT_W +: CNT_W]));
        // R3: in strobe mode, no strobe means no step.
        p_no_step_without_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (!clksel_q && !fclk_en) |=> $stable(count_all[t*CNT_W +: CNT_W]));
        // R9: a capture register changes only on a strobe.
        p_capture_only_on_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (!fclk_en && !(bus_we && bus_addr == ADDR_W'(ADR_CAPTURE + t)))
            |=> $stable(cap_all[t*CNT_W +: CNT_W]));
    end

    for (genvar i = 0; i < NUM_TIMERS*NUM_MATCH; i++) begin : g_i
        // R8: a match pulse is always accompanied by its status bit.
        p_pulse_sets_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
            match_pulse[i] |-> match_status[i]);
        // R8: status stays set unless cleared by a write of 1.
        p_status_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (match_status[i] && !(bus_we && bus_addr == ADDR_W'(ADR_STATUS) && bus_wdata[i]))
            |=> match_status[i]);
        // R7: a pulse only follows a cycle in which its timer ran.
        p_pulse_needs_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
            match_pulse[i] |-> $past(en_q[i / NUM_MATCH]));
    end
endmodule

bind mmt_top mmt_checker #(
    .NUM_TIMERS (NUM_TIMERS),
    .NUM_MATCH  (NUM_MATCH),
    .CNT_W      (CNT_W),
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W)
) u_mmt_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .fclk_en      (fclk_en),
    .bus_we       (bus_we),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .clksel_q     (clksel_q),
    .en_q         (en_q),
    .count_all    (count_all),
    .cap_all      (cap_all),
    .match_pulse  (match_pulse),
    .match_status (match_status)
);

// File: tb/test_mmt_top.sv
`timescale 1ns/1ps
// Bench: reload vectors from a table, then directed tests for reset, enables,
// clock select, preload timing, match pulses, status and capture latency.
module test_mmt_top;
    localparam int NT = 3, NM = 3, CW = 8, DW = 32, AW = 5;

    typedef struct packed {
        int m0; int m1; int m2; int pre; int sel; int ticks; int expv;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{5,   255, 255, 2,   1, 10,  2},    // R4 reload from comparator 0
        '{5,   255, 255, 2,   0, 10,  10},   // R4 selector 0: no reload
        '{2,   3,   255, 7,   2, 6,   9},    // R4 comparator 1 reloads, comparator 0 does not
        '{255, 255, 0,   100, 3, 3,   102},  // R4 comparator 2 reloads at count 0
        '{255, 255, 255, 0,   1, 258, 2},    // R5 full range via comparator 0
        '{255, 255, 255, 0,   0, 300, 44},   // R5 natural wrap
        '{0,   255, 255, 0,   1, 5,   0}     // R4 reload to same value
    };

    logic          clk = 0;
    logic          rst_n = 0;
    logic          fclk_en = 0;
    logic          bus_we = 0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic [NT*NM-1:0] match_pulse, match_status;
    int total = 0, bad = 0;
    logic [DW-1:0] rd;

    always #2 clk = ~clk;

    mmt_top #(.NUM_TIMERS(NT), .NUM_MATCH(NM), .CNT_W(CW), .DATA_W(DW), .ADDR_W(AW)) i_mmt_top (
        .clk(clk), .rst_n(rst_n), .fclk_en(fclk_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .match_pulse(match_pulse),
        .match_status(match_status));

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; fclk_en = 0; bus_we = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic wr(input int addr, input logic [DW-1:0] data);
        @(negedge clk);
        bus_we = 1; bus_addr = AW'(addr); bus_wdata = data;
        @(negedge clk);
        bus_we = 0;
    endtask

    task automatic rdreg(input int addr, output logic [DW-1:0] data);
        @(negedge clk);
        bus_addr = AW'(addr);
        #1 data = bus_rdata;
    endtask

    task automatic tick();
        @(negedge clk);
        fclk_en = 1;
        @(negedge clk);
        fclk_en = 0;
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) tick();
    endtask

    task automatic read_count(input int t, output logic [DW-1:0] data);
        wr(12 + t, 1);
        tick();
        tick();
        rdreg(12 + t, data);
    endtask

    initial begin
        #800000;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset state
        do_reset();
        rdreg(0, rd);  check("R1 clksel", rd, 0);
        rdreg(1, rd);  check("R1 enable", rd, 0);
        rdreg(2, rd);  check("R1 status", rd, 0);
        rdreg(8, rd);  check("R1 reload selector", rd, 0);
        rdreg(12, rd); check("R1 capture", rd, 0);
        rdreg(16, rd); check("R1 match reset", rd, 8'hFF);
        check("R1 pulse", DW'(match_pulse), 0);
        check("R1 status pins", DW'(match_status), 0);

        // Vector table: R4 / R5 reload and wrap on timer 0
        foreach (VECS[v]) begin
            do_reset();
            wr(16, VECS[v].m0); wr(17, VECS[v].m1); wr(18, VECS[v].m2);
            wr(4, VECS[v].pre); wr(8, VECS[v].sel);
            wr(1, 1);
            ticks(VECS[v].ticks);
            wr(1, 0);
            read_count(0, rd);
            check(VECS[v].sel == 0 && VECS[v].ticks > 255 ? "R5 wrap" : "R4 reload", rd, VECS[v].expv);
        end

        // R2: disabled timer holds, enabled timer counts
        do_reset();
        ticks(4);
        read_count(0, rd); check("R2 disabled holds", rd, 0);
        wr(1, 1); ticks(6); wr(1, 0);
        ticks(3);
        read_count(0, rd); check("R2 counts when enabled", rd, 6);

        // R3: clock select 1 counts every clock regardless of fclk_en
        do_reset();
        wr(0, 1);
        rdreg(0, rd); check("R3 clksel readback", rd, 1);
        wr(1, 1);
        repeat (8) @(negedge clk);
        wr(1, 0);
        read_count(0, rd); check("R3 every-clock count", rd, 10);

        // R6: preload change while running waits for the next reload
        do_reset();
        wr(16, 4); wr(4, 1); wr(8, 1); wr(1, 1);
        ticks(2);
        wr(4, 9);
        tick();
        wr(1, 0);
        read_count(0, rd); check("R6 no immediate effect", rd, 3);
        wr(1, 1); ticks(2); wr(1, 0);
        read_count(0, rd); check("R6 new preload at reload", rd, 9);

        // R7 / R8: one-cycle pulse, sticky status, write-one-to-clear
        do_reset();
        wr(17, 3); wr(1, 1);
        ticks(3);
        @(negedge clk); fclk_en = 1;
        @(negedge clk);
        check("R7 pulse bit 1", DW'(match_pulse), 32'h2);
        check("R8 status set with pulse", DW'(match_status), 32'h2);
        fclk_en = 0;
        @(negedge clk);
        check("R7 pulse lasts one cycle", DW'(match_pulse), 0);
        check("R8 status sticky", DW'(match_status), 32'h2);
        rdreg(2, rd); check("R8 status readback", rd, 32'h2);
        wr(2, 32'h1);
        rdreg(2, rd); check("R8 clear of other bit ignored", rd, 32'h2);
        wr(2, 32'h2);
        rdreg(2, rd); check("R8 cleared", rd, 0);

        // R9: capture latency of two strobes, previous value until then
        do_reset();
        wr(1, 1); ticks(5); wr(1, 0);
        wr(12, 1);
        rdreg(12, rd); check("R9 before any strobe", rd, 0);
        tick();
        rdreg(12, rd); check("R9 after one strobe", rd, 0);
        tick();
        rdreg(12, rd); check("R9 after two strobes", rd, 5);
        wr(1, 1); ticks(2); wr(1, 0);
        wr(12, 1); tick();
        rdreg(12, rd); check("R9 keeps previous capture", rd, 5);
        tick();
        rdreg(12, rd); check("R9 second capture", rd, 7);

        // R10: match register readback at 16+3t+c
        wr(20, 32'h5A);
        rdreg(20, rd); check("R10 match t1 c1", rd, 32'h5A);
        rdreg(19, rd); check("R10 neighbour untouched", rd, 8'hFF);

        // R11: timer 1 alone runs and matches comparator 2 (status bit 5)
        do_reset();
        wr(21, 2); wr(1, 2);
        ticks(3);
        wr(1, 0);
        check("R11 status bit 5 only", DW'(match_status), 32'h20);
        read_count(1, rd); check("R11 timer 1 count", rd, 3);
        read_count(0, rd); check("R11 timer 0 untouched", rd, 0);
        read_count(2, rd); check("R11 timer 2 untouched", rd, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule